// File: doc/BRIEF.md
# Redundant-Execution Fault Check Controller

This controller sits between a requester and a block-cipher engine and guards the engine against injected faults by doing the work a second time. The requester raises a start strobe with a data word and a mode bit. The controller latches the word and drives the engine through a start/done handshake twice. After both runs it decides whether the result may leave the block.

In double-run mode the same word is encrypted twice, and the two ciphertexts must agree. In verify mode the word is encrypted and that ciphertext is then decrypted, and the recovered value must equal the latched word. Before each engine launch a pseudo-random wait of a few cycles is inserted, so that an attacker cannot predict in which clock cycle the engine is working. Environmental sensor flags, for example temperature or supply out of range, are also watched for the whole operation.

Any disagreement, or any sensor flag seen during the operation, withholds the result and raises an alarm. The alarm stays set until reset and blocks all later work.

Top module: `redun_guard`

## Requirements
- R1: With mode_i=0 the engine is launched twice, both times with eng_decrypt_o=0 and eng_data_o equal to the latched word. If both results agree, result_o carries that ciphertext, valid_o is 1, and done_o pulses.
- R2: With mode_i=1 the first launch has eng_decrypt_o=0 on the latched word. The second launch has eng_decrypt_o=1 on the first result. The output is released, carrying the first result, only when the decrypted value equals the latched word.
- R3: When the check fails, result_o is all zeros, valid_o is 0, done_o does not pulse, and alarm_o goes to 1.
- R4: Once alarm_o is 1, only reset clears it. While it is set, start_i is refused and eng_start_o stays 0.
- R5: A sensor_i bit that is 1 in any cycle from the cycle after acceptance through the compare cycle fails the operation. A sensor pulse while the controller is idle does not affect the next operation.
- R6: data_i and mode_i are captured in the cycle start_i is accepted. Changing them afterwards does not change what the engine receives or the released result.
- R7: done_o is high for exactly one cycle per released result. valid_o and result_o hold their values until the next start is accepted.
- R8: Each engine launch is preceded by a pseudo-random wait of 0 to 2^JITTER_BITS-1 cycles. eng_start_o is a single-cycle pulse that appears 2 to 2^JITTER_BITS+1 cycles after the start_i sampling edge's preceding falling edge, and the wait varies from operation to operation.
- R9: After reset, eng_start_o, result_o, valid_o, done_o and alarm_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request an operation; accepted only when idle |
| mode_i | input | 1 | 0 = double encryption, 1 = encrypt then decrypt |
| data_i | input | DATA_W | Word to encrypt |
| sensor_i | input | SENS_N | Environmental out-of-range flags |
| eng_start_o | output | 1 | One-cycle launch pulse to the engine |
| eng_decrypt_o | output | 1 | Engine direction, 1 = decrypt |
| eng_data_o | output | DATA_W | Engine input word |
| eng_done_i | input | 1 | Engine finished, eng_data_i valid |
| eng_data_i | input | DATA_W | Engine output word |
| result_o | output | DATA_W | Released ciphertext, zero unless valid |
| valid_o | output | 1 | result_o holds a checked ciphertext |
| done_o | output | 1 | One-cycle pulse when a result is released |
| alarm_o | output | 1 | Sticky fault alarm |

## Verification
Several rules are checked in every cycle by assertions. These are: the single-cycle done and launch pulses, the stickiness of the alarm, the absence of launches under alarm, and the zeroed result under alarm. A further assertion checks that the engine input stays steady within a run.

Whether the released word is the correct ciphertext, and whether the second run is really a decryption of the first result, needs the bench's model engine. The same holds for whether a fault in either run or a sensor pulse mid-operation is caught, and whether the launch wait varies. The bench sweeps every data value in both modes and flips each bit in each run.

// File: rtl/redun_pkg.sv
package redun_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN1  = 3'd1,
    ST_RUN2  = 3'd2,
    ST_CMP   = 3'd3,
    ST_DONE  = 3'd4,
    ST_ALARM = 3'd5
  } rg_state_t;
endpackage

// File: rtl/redun_jitter_lfsr.sv
module redun_jitter_lfsr #(
  parameter int          LFSR_W = 16,
  parameter logic [15:0] TAPS   = 16'hB400,
  parameter logic [15:0] SEED   = 16'hACE1,
  parameter int          OUT_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] tap_o
);
  logic [LFSR_W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= SEED[LFSR_W-1:0];
    end else if (q[0]) begin
      q <= (q >> 1) ^ TAPS[LFSR_W-1:0];
    end else begin
      q <= q >> 1;
    end
  end

  assign tap_o = q[OUT_W-1:0];
endmodule

// File: rtl/redun_sensor_watch.sv
module redun_sensor_watch #(
  parameter int SENS_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              active_i,
  input  logic [SENS_N-1:0] sensor_i,
  output logic              hit_o
);
  logic hit_q;
  logic now_hit;

  assign now_hit = active_i && (|sensor_i);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      hit_q <= 1'b0;
    end else if (now_hit) begin
      hit_q <= 1'b1;
    end
  end

  assign hit_o = hit_q || now_hit;
endmodule

// File: rtl/redun_check.sv
module redun_check #(
  parameter int DATA_W = 64
) (
  input  logic              verify_i,
  input  logic [DATA_W-1:0] orig_i,
  input  logic [DATA_W-1:0] first_i,
  input  logic [DATA_W-1:0] second_i,
  input  logic              sens_hit_i,
  output logic              pass_o
);
  logic [DATA_W-1:0] want;

  always_comb begin
    want   = verify_i ? orig_i : first_i;
    pass_o = !sens_hit_i && (second_i == want);
  end
endmodule

// File: rtl/redun_guard.sv
module redun_guard
  import redun_pkg::*;
#(
  parameter int          DATA_W      = 64,
  parameter int          SENS_N      = 2,
  parameter int          JITTER_BITS = 3,
  parameter int          LFSR_W      = 16,
  parameter logic [15:0] LFSR_TAPS   = 16'hB400,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SENS_N-1:0] sensor_i,
  output logic              eng_start_o,
  output logic              eng_decrypt_o,
  output logic [DATA_W-1:0] eng_data_o,
  input  logic              eng_done_i,
  input  logic [DATA_W-1:0] eng_data_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              done_o,
  output logic              alarm_o
);
  localparam int JW = (JITTER_BITS > 0) ? JITTER_BITS : 1;

  rg_state_t         state_q;
  logic [DATA_W-1:0] in_q, r1_q, r2_q, result_q;
  logic              mode_q, launched_q, eng_start_q;
  logic              valid_q, done_q, alarm_q;
  logic [JW-1:0]     dly_q;
  logic [JW-1:0]     jit_val;
  logic              accept, op_active, sens_hit, pass;
  logic              in_run;

  generate
    if (JITTER_BITS > 0) begin : g_jit
      redun_jitter_lfsr #(
        .LFSR_W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED), .OUT_W(JW)
      ) u_lfsr (
        .clk(clk), .rst(rst), .tap_o(jit_val)
      );
    end else begin : g_nojit
      assign jit_val = '0;
    end
  endgenerate

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign in_run    = (state_q == ST_RUN1) || (state_q == ST_RUN2);
  assign op_active = in_run || (state_q == ST_CMP);

  redun_sensor_watch #(.SENS_N(SENS_N)) u_watch (
    .clk(clk), .rst(rst), .clear_i(accept), .active_i(op_active),
    .sensor_i(sensor_i), .hit_o(sens_hit)
  );

  redun_check #(.DATA_W(DATA_W)) u_check (
    .verify_i(mode_q), .orig_i(in_q), .first_i(r1_q), .second_i(r2_q),
    .sens_hit_i(sens_hit), .pass_o(pass)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      in_q        <= '0;
      r1_q        <= '0;
      r2_q        <= '0;
      result_q    <= '0;
      mode_q      <= 1'b0;
      launched_q  <= 1'b0;
      eng_start_q <= 1'b0;
      valid_q     <= 1'b0;
      done_q      <= 1'b0;
      alarm_q     <= 1'b0;
      dly_q       <= '0;
    end else begin
      eng_start_q <= 1'b0;
      done_q      <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            in_q       <= data_i;
            mode_q     <= mode_i;
            dly_q      <= jit_val;
            launched_q <= 1'b0;
            valid_q    <= 1'b0;
            result_q   <= '0;
            state_q    <= ST_RUN1;
          end
        end
        ST_RUN1, ST_RUN2: begin
          if (dly_q != '0) begin
            dly_q <= dly_q - 1'b1;
          end else if (!launched_q) begin
            eng_start_q <= 1'b1;
            launched_q  <= 1'b1;
          end else if (eng_done_i) begin
            if (state_q == ST_RUN1) begin
              r1_q       <= eng_data_i;
              dly_q      <= jit_val;
              launched_q <= 1'b0;
              state_q    <= ST_RUN2;
            end else begin
              r2_q    <= eng_data_i;
              state_q <= ST_CMP;
            end
          end
        end
        ST_CMP: begin
          if (pass) begin
            result_q <= r1_q;
            valid_q  <= 1'b1;
            done_q   <= 1'b1;
            state_q  <= ST_DONE;
          end else begin
            result_q <= '0;
            valid_q  <= 1'b0;
            alarm_q  <= 1'b1;
            state_q  <= ST_ALARM;
          end
        end
        ST_DONE:  state_q <= ST_IDLE;
        ST_ALARM: state_q <= ST_ALARM;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign eng_start_o   = eng_start_q;
  assign eng_decrypt_o = (state_q == ST_RUN2) && mode_q;
  assign eng_data_o    = ((state_q == ST_RUN2) && mode_q) ? r1_q : in_q;
  assign result_o      = result_q;
  assign valid_o       = valid_q;
  assign done_o        = done_q;
  assign alarm_o       = alarm_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    done_o |-> valid_o); // R1
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    alarm_o |=> alarm_o); // R4
  AST_ALARM_NO_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    alarm_o |-> !eng_start_o); // R4
  AST_ALARM_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
    alarm_o |-> (!valid_o && result_o == '0 && !done_o)); // R3
  AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (rst)
    eng_start_o |=> !eng_start_o); // R8
  AST_ENG_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (in_run && state_q == $past(state_q)) |-> $stable(eng_data_o)); // R6
endmodule

// File: tb/tb_redun_guard.sv
`timescale 1ns/1ps
module tb_redun_guard;
  localparam int W   = 8;
  localparam int JB  = 2;
  localparam int LAT = 2;
  localparam logic [W-1:0] KEY = 8'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, mode_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [1:0] sensor_i = '0;
  logic eng_start_o, eng_decrypt_o, eng_done_i = 1'b0;
  logic [W-1:0] eng_data_o, eng_data_i = '0, result_o;
  logic valid_o, done_o, alarm_o;

  int checks = 0, errors = 0;
  int cyc = 0, eng_starts = 0, flt_at = -1;
  logic [W-1:0] flt_mask = '0;
  logic [W-1:0] seen_in [0:4095];
  logic         seen_dec[0:4095];
  int           seen_cyc[0:4095];
  int eng_cnt = 0;
  logic eng_busy = 1'b0;
  logic [W-1:0] eng_res = '0;
  logic [7:0] gap_seen = '0;

  always #2.5 clk = ~clk;

  redun_guard #(.DATA_W(W), .SENS_N(2), .JITTER_BITS(JB)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i), .data_i(data_i),
    .sensor_i(sensor_i), .eng_start_o(eng_start_o), .eng_decrypt_o(eng_decrypt_o),
    .eng_data_o(eng_data_o), .eng_done_i(eng_done_i), .eng_data_i(eng_data_i),
    .result_o(result_o), .valid_o(valid_o), .done_o(done_o), .alarm_o(alarm_o));

  function automatic logic [W-1:0] enc(input logic [W-1:0] x);
    return {x[W-4:0], x[W-1:W-3]} ^ KEY;
  endfunction
  function automatic logic [W-1:0] dec(input logic [W-1:0] y);
    logic [W-1:0] t;
    t = y ^ KEY;
    return {t[2:0], t[W-1:3]};
  endfunction

  // stand-in engine, acts on falling edges
  always @(negedge clk) begin
    cyc = cyc + 1;
    eng_done_i = 1'b0;
    if (eng_busy) begin
      if (eng_cnt == 0) begin
        eng_done_i = 1'b1;
        eng_data_i = eng_res;
        eng_busy = 1'b0;
      end else eng_cnt = eng_cnt - 1;
    end
    if (eng_start_o) begin
      eng_starts = eng_starts + 1;
      seen_in[eng_starts % 4096]  = eng_data_o;
      seen_dec[eng_starts % 4096] = eng_decrypt_o;
      seen_cyc[eng_starts % 4096] = cyc;
      eng_res = eng_decrypt_o ? dec(eng_data_o) : enc(eng_data_o);
      if (eng_starts == flt_at) eng_res = eng_res ^ flt_mask;
      eng_cnt = LAT;
      eng_busy = 1'b1;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst = 1'b1; start_i = 1'b0; sensor_i = '0; flt_at = -1;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
  endtask

  // runs one operation; returns what was observed
  task automatic do_op(input logic md, input logic [W-1:0] d, input int frun,
                       input logic [W-1:0] fmask, input int sens_at,
                       output logic got_done, output logic got_alarm,
                       output logic [W-1:0] res, output logic vld,
                       output int base, output int t0);
    int k;
    @(negedge clk); #1;
    base = eng_starts;
    flt_at = (frun > 0) ? base + frun : -1;
    flt_mask = fmask;
    t0 = cyc;
    start_i = 1'b1; mode_i = md; data_i = d;
    @(negedge clk); #1;
    start_i = 1'b0; data_i = ~d; mode_i = ~md;   // R6: inputs change after capture
    got_done = 1'b0; got_alarm = 1'b0; res = '0; vld = 1'b0;
    k = 1;
    while (k < 200 && !got_done && !got_alarm) begin
      sensor_i = (k == sens_at) ? 2'b10 : 2'b00;
      if (done_o) begin got_done = 1'b1; res = result_o; vld = valid_o; end
      else if (alarm_o) begin got_alarm = 1'b1; res = result_o; vld = valid_o; end
      else begin @(negedge clk); #1; k = k + 1; end
    end
    sensor_i = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1; errors = errors + 1;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic gd, ga, vl;
    logic [W-1:0] rs;
    int base, t0, gap, nstarts;
    do_reset();
    // R9 reset state
    chk(eng_start_o == 0 && result_o == 0 && valid_o == 0 && done_o == 0 && alarm_o == 0,
        "R9 reset outputs", {eng_start_o, done_o, valid_o, alarm_o}, 0);

    // sweep both modes, every value, no fault
    for (int md = 0; md < 2; md++) begin
      for (int v = 0; v < 256; v++) begin
        do_op(md[0], v[W-1:0], 0, '0, 0, gd, ga, rs, vl, base, t0);
        chk(gd && !ga && vl, md ? "R2 release" : "R1 release", {gd, ga, vl}, 3'b101);
        chk(rs == enc(v[W-1:0]), "R6 R1 R2 result", rs, enc(v[W-1:0]));
        if (md == 0)
          chk(seen_in[(base+1)%4096] == v[W-1:0] && seen_in[(base+2)%4096] == v[W-1:0] &&
              !seen_dec[(base+1)%4096] && !seen_dec[(base+2)%4096],
              "R1 engine inputs", seen_in[(base+2)%4096], v);
        else
          chk(seen_in[(base+1)%4096] == v[W-1:0] && !seen_dec[(base+1)%4096] &&
              seen_in[(base+2)%4096] == enc(v[W-1:0]) && seen_dec[(base+2)%4096],
              "R2 engine inputs", seen_in[(base+2)%4096], enc(v[W-1:0]));
        gap = seen_cyc[(base+1)%4096] - t0;
        chk(gap >= 2 && gap <= (1 << JB) + 1, "R8 launch wait", gap, 2);
        if (gap >= 0 && gap < 8) gap_seen[gap] = 1'b1;
        @(negedge clk); #1;
        chk(!done_o && valid_o && result_o == enc(v[W-1:0]), "R7 pulse and hold",
            {done_o, valid_o}, 2'b01);
      end
    end
    chk($countones(gap_seen) >= 2, "R8 wait varies", $countones(gap_seen), 2);

    // single-bit faults in either run, both modes
    for (int md = 0; md < 2; md++) begin
      for (int fr = 1; fr <= 2; fr++) begin
        for (int b = 0; b < W; b++) begin
          do_reset();
          do_op(md[0], 8'h3C ^ b[W-1:0], fr, 8'(1 << b), 0, gd, ga, rs, vl, base, t0);
          chk(ga && !gd && !vl && rs == 0, "R3 fault caught", {gd, ga, vl}, 3'b010);
          nstarts = eng_starts;
          @(negedge clk); #1;
          start_i = 1'b1; data_i = 8'h11; mode_i = 1'b0;
          repeat (12) @(negedge clk);
          #1 start_i = 1'b0;
          chk(eng_starts == nstarts && alarm_o, "R4 refuse under alarm", eng_starts - nstarts, 0);
        end
      end
    end

    // alarm cleared only by reset
    do_reset();
    chk(!alarm_o, "R4 reset clears alarm", alarm_o, 0);

    // sensor during an operation
    for (int sa = 1; sa <= 6; sa++) begin
      do_reset();
      do_op(1'b0, 8'hA5, 0, '0, sa, gd, ga, rs, vl, base, t0);
      chk(ga && !gd && rs == 0, "R5 sensor in operation", {gd, ga}, 2'b01);
    end
    // sensor while idle is ignored
    do_reset();
    @(negedge clk); #1 sensor_i = 2'b01;
    @(negedge clk); #1 sensor_i = 2'b00;
    do_op(1'b1, 8'h77, 0, '0, 0, gd, ga, rs, vl, base, t0);
    chk(gd && !ga && rs == enc(8'h77), "R5 idle sensor ignored", rs, enc(8'h77));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule